// File: doc/BRIEF.md
# Record Spacing Sequencer

The sequencer runs the tape space-forward and space-backward commands. A start pulse loads a 16-bit frame count and latches a direction. The count is the two's-complement negative of the number of records to pass over. The block then asks a record-skip agent to pass over one record at a time. After each request it waits for a single response. Each response reports a plain skip, a tape mark, the beginning of tape, or the end of the medium.

Every plain skip increments the count. When the count wraps to zero, the command has moved the requested number of records and finishes cleanly. A tape mark or either end of the tape stops the command early. In that case the count keeps the number of records still owed. A programmable idle gap separates successive requests.

Every command ends with a one-cycle completion pulse that carries an attention request. The error and status flags stay readable until the next command starts. A zero count at start is refused: the block sets an error and moves no tape.

Top module: `tape_space_seq`

## Requirements
- R1: After reset, busy, motion, skipReq, donePulse, attnReq, errNef, errFce and tapeMark are all low, and frameCount is zero.
- R2: A start pulse while idle loads frameCountIn, latches dirRev and clears all three flags. A start pulse while busy has no effect on the count, the direction or the flags.
- R3: If the loaded count is zero, no skip request is issued. donePulse rises on the second clock edge after the start edge, with errNef set.
- R4: Each skip request is a one-cycle skipReq pulse, and no further request is issued until a response arrives. skipDir equals the latched direction throughout: 0 means forward, 1 means backward.
- R5: Response code 0 (plain skip) increments frameCount by one. If the result is zero, the command completes with no error flag set. Otherwise another skip follows.
- R6: After a code-0 response that does not complete the command, the next skipReq is seen on the (gapCycles+2)-th rising edge after the edge that accepted the response.
- R7: Response codes 1 (tape mark), 2 (beginning of tape) and 3 (end of medium) end the command. donePulse is asserted in the next cycle and frameCount is left unchanged. errFce is set exactly when that count is nonzero.
- R8: Code 1 additionally sets tapeMark. Code 2 additionally sets errNef.
- R9: donePulse lasts one cycle, with attnReq asserted alongside it. busy falls right after it, and the flags hold their values until the next accepted start.
- R10: motion is high on every cycle with skipReq and stays high until the done pulse. It is low during the done pulse and while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Command start pulse |
| dirRev | input | 1 | Direction: 0 forward, 1 backward |
| frameCountIn | input | CNT_W | Negative record count to preload |
| gapCycles | input | GAP_W | Idle cycles between skips |
| skipAck | input | 1 | Skip response valid |
| skipResp | input | 2 | Response code: 0 ok, 1 mark, 2 start of tape, 3 end of medium |
| skipReq | output | 1 | One-cycle skip request |
| skipDir | output | 1 | Latched direction of the request |
| busy | output | 1 | Command in progress (GO) |
| motion | output | 1 | Tape in motion |
| frameCount | output | CNT_W | Current frame count |
| donePulse | output | 1 | One-cycle completion pulse |
| attnReq | output | 1 | Attention request, with donePulse |
| errNef | output | 1 | Non-executable function error |
| errFce | output | 1 | Frame count error |
| tapeMark | output | 1 | Tape mark encountered |

## Verification
The properties assume a well-behaved skip agent. skipAck arrives only while a request is outstanding, with exactly one response per request, and gapCycles holds steady while a command runs. The bench enforces this with a stub that watches skipReq on falling edges. The stub answers each request once, after a fixed latency, drops skipAck on the next falling edge, and only changes gapCycles between commands. Start pulses that arrive mid-command are the one deliberate excursion, and they are covered by the ignore requirement.

// File: rtl/tss_pkg.sv
package tss_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_CHECK = 3'd1,
    ST_REQ   = 3'd2,
    ST_WAIT  = 3'd3,
    ST_GAP   = 3'd4,
    ST_DONE  = 3'd5
  } seqState_t;

  typedef enum logic [1:0] {
    RESP_OK   = 2'd0,
    RESP_MARK = 2'd1,
    RESP_BOT  = 2'd2,
    RESP_EOM  = 2'd3
  } skipResp_t;

  // strobes from control to datapath
  typedef struct packed {
    logic loadCount;
    logic incCount;
    logic clrGap;
    logic incGap;
    logic setNef;
    logic setFce;
    logic setMark;
  } dpCtrl_t;

endpackage

// File: rtl/tss_datapath.sv
module tss_datapath
  import tss_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int GAP_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpCtrl_t          ctl,
  input  logic [CNT_W-1:0] countIn,
  input  logic             dirIn,
  input  logic [GAP_W-1:0] gapCycles,
  output logic [CNT_W-1:0] frameCount,
  output logic             dirLatched,
  output logic             countZero,
  output logic             countAllOnes,
  output logic             gapDone,
  output logic             errNef,
  output logic             errFce,
  output logic             markSeen
);

  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);
  localparam logic [GAP_W-1:0] GAP_ONE = GAP_W'(1);

  logic [CNT_W-1:0] countQ;
  logic [GAP_W-1:0] gapQ;
  logic             dirQ;
  logic             nefQ, fceQ, markQ;

  // frame counter: preload on start, wrap-around increment per skip
  always_ff @(posedge clk) begin
    if (!rstN) begin
      countQ <= '0;
      dirQ   <= 1'b0;
    end else if (ctl.loadCount) begin
      countQ <= countIn;
      dirQ   <= dirIn;
    end else if (ctl.incCount) begin
      countQ <= countQ + CNT_ONE;
    end
  end

  // inter-record gap timer
  always_ff @(posedge clk) begin
    if (!rstN) begin
      gapQ <= '0;
    end else if (ctl.clrGap) begin
      gapQ <= '0;
    end else if (ctl.incGap) begin
      gapQ <= gapQ + GAP_ONE;
    end
  end

  // sticky completion flags, cleared by an accepted start
  always_ff @(posedge clk) begin
    if (!rstN) begin
      nefQ  <= 1'b0;
      fceQ  <= 1'b0;
      markQ <= 1'b0;
    end else if (ctl.loadCount) begin
      nefQ  <= 1'b0;
      fceQ  <= 1'b0;
      markQ <= 1'b0;
    end else begin
      if (ctl.setNef)  nefQ  <= 1'b1;
      if (ctl.setFce)  fceQ  <= 1'b1;
      if (ctl.setMark) markQ <= 1'b1;
    end
  end

  assign frameCount   = countQ;
  assign dirLatched   = dirQ;
  assign countZero    = (countQ == '0);
  assign countAllOnes = &countQ;
  assign gapDone      = (gapQ == gapCycles);
  assign errNef       = nefQ;
  assign errFce       = fceQ;
  assign markSeen     = markQ;

endmodule

// File: rtl/tss_ctrl.sv
module tss_ctrl
  import tss_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       skipAck,
  input  logic [1:0] skipResp,
  input  logic       countZero,
  input  logic       countAllOnes,
  input  logic       gapDone,
  output dpCtrl_t    ctl,
  output logic       skipReq,
  output logic       busy,
  output logic       motion,
  output logic       donePulse
);

  seqState_t state, nextState;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    ctl       = '0;
    unique case (state)
      ST_IDLE: begin
        if (start) begin
          ctl.loadCount = 1'b1;
          nextState     = ST_CHECK;
        end
      end
      ST_CHECK: begin
        if (countZero) begin
          ctl.setNef = 1'b1;
          nextState  = ST_DONE;
        end else begin
          nextState  = ST_REQ;
        end
      end
      ST_REQ: nextState = ST_WAIT;
      ST_WAIT: begin
        if (skipAck) begin
          unique case (skipResp_t'(skipResp))
            RESP_OK: begin
              ctl.incCount = 1'b1;
              if (countAllOnes) begin
                nextState = ST_DONE;
              end else begin
                ctl.clrGap = 1'b1;
                nextState  = ST_GAP;
              end
            end
            RESP_MARK: begin
              ctl.setMark = 1'b1;
              ctl.setFce  = !countZero;
              nextState   = ST_DONE;
            end
            RESP_BOT: begin
              ctl.setNef = 1'b1;
              ctl.setFce = !countZero;
              nextState  = ST_DONE;
            end
            default: begin
              ctl.setFce = !countZero;
              nextState  = ST_DONE;
            end
          endcase
        end
      end
      ST_GAP: begin
        if (gapDone) nextState = ST_REQ;
        else         ctl.incGap = 1'b1;
      end
      ST_DONE: nextState = ST_IDLE;
      default: nextState = ST_IDLE;
    endcase
  end

  assign skipReq   = (state == ST_REQ);
  assign busy      = (state != ST_IDLE);
  assign motion    = (state == ST_REQ) || (state == ST_WAIT) || (state == ST_GAP);
  assign donePulse = (state == ST_DONE);

endmodule

// File: rtl/tape_space_seq.sv
module tape_space_seq
  import tss_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int GAP_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic             dirRev,
  input  logic [CNT_W-1:0] frameCountIn,
  input  logic [GAP_W-1:0] gapCycles,
  input  logic             skipAck,
  input  logic [1:0]       skipResp,
  output logic             skipReq,
  output logic             skipDir,
  output logic             busy,
  output logic             motion,
  output logic [CNT_W-1:0] frameCount,
  output logic             donePulse,
  output logic             attnReq,
  output logic             errNef,
  output logic             errFce,
  output logic             tapeMark
);

  dpCtrl_t ctl;
  logic    countZero, countAllOnes, gapDone;

  tss_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .start        (start),
    .skipAck      (skipAck),
    .skipResp     (skipResp),
    .countZero    (countZero),
    .countAllOnes (countAllOnes),
    .gapDone      (gapDone),
    .ctl          (ctl),
    .skipReq      (skipReq),
    .busy         (busy),
    .motion       (motion),
    .donePulse    (donePulse)
  );

  tss_datapath #(.CNT_W(CNT_W), .GAP_W(GAP_W)) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .ctl          (ctl),
    .countIn      (frameCountIn),
    .dirIn        (dirRev),
    .gapCycles    (gapCycles),
    .frameCount   (frameCount),
    .dirLatched   (skipDir),
    .countZero    (countZero),
    .countAllOnes (countAllOnes),
    .gapDone      (gapDone),
    .errNef       (errNef),
    .errFce       (errFce),
    .markSeen     (tapeMark)
  );

  assign attnReq = donePulse;

endmodule

// File: rtl/tss_checker.sv
module tss_checker #(
  parameter int CNT_W = 16,
  parameter int GAP_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             start,
  input logic [CNT_W-1:0] frameCountIn,
  input logic [GAP_W-1:0] gapCycles,
  input logic             skipAck,
  input logic [1:0]       skipResp,
  input logic             skipReq,
  input logic             busy,
  input logic             motion,
  input logic [CNT_W-1:0] frameCount,
  input logic             donePulse,
  input logic             attnReq,
  input logic             errNef,
  input logic             errFce,
  input logic             tapeMark
);

  logic             armed;
  logic [GAP_W+1:0] gapCtr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      armed  <= 1'b0;
      gapCtr <= '0;
    end else if (busy && skipAck && skipResp == 2'd0) begin
      armed  <= 1'b1;
      gapCtr <= '0;
    end else if (skipReq || donePulse) begin
      armed  <= 1'b0;
    end else if (armed) begin
      gapCtr <= gapCtr + 1'b1;
    end
  end

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!skipReq && !motion && !donePulse));

  a_r2_busy_count_hold: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !skipAck) |=> $stable(frameCount));

  a_r3_zero_count: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && start && frameCountIn == '0) |=> !skipReq ##1 (donePulse && errNef && !skipReq));

  a_r4_single_req: assert property (@(posedge clk) disable iff (!rstN)
    skipReq |=> !skipReq);

  a_r5_count_inc: assert property (@(posedge clk) disable iff (!rstN)
    (busy && skipAck && skipResp == 2'd0) |=> frameCount == CNT_W'($past(frameCount) + 1'b1));

  a_r6_gap_length: assert property (@(posedge clk) disable iff (!rstN)
    (skipReq && armed) |-> gapCtr == ({2'b00, gapCycles} + 1'b1));

  a_r7_early_stop: assert property (@(posedge clk) disable iff (!rstN)
    (busy && skipAck && skipResp != 2'd0) |=>
      (donePulse && $stable(frameCount) && (errFce == (frameCount != '0))));

  a_r8_mark_flag: assert property (@(posedge clk) disable iff (!rstN)
    (busy && skipAck && skipResp == 2'd1) |=> tapeMark);

  a_r8_bot_flag: assert property (@(posedge clk) disable iff (!rstN)
    (busy && skipAck && skipResp == 2'd2) |=> errNef);

  a_r9_done_once: assert property (@(posedge clk) disable iff (!rstN)
    donePulse |=> (!donePulse && !busy));

  a_r9_attn_with_done: assert property (@(posedge clk) disable iff (!rstN)
    donePulse |-> attnReq);

  a_r10_motion_req: assert property (@(posedge clk) disable iff (!rstN)
    skipReq |-> motion);

  a_r10_motion_done: assert property (@(posedge clk) disable iff (!rstN)
    donePulse |-> !motion);

endmodule

bind tape_space_seq tss_checker #(.CNT_W(CNT_W), .GAP_W(GAP_W)) u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .start        (start),
  .frameCountIn (frameCountIn),
  .gapCycles    (gapCycles),
  .skipAck      (skipAck),
  .skipResp     (skipResp),
  .skipReq      (skipReq),
  .busy         (busy),
  .motion       (motion),
  .frameCount   (frameCount),
  .donePulse    (donePulse),
  .attnReq      (attnReq),
  .errNef       (errNef),
  .errFce       (errFce),
  .tapeMark     (tapeMark)
);

// File: tb/tape_space_seq_tb.sv
module tape_space_seq_tb;

  localparam int CNT_W = 16;
  localparam int GAP_W = 8;

  typedef struct {
    logic             nef;
    logic             fce;
    logic             mark;
    int               skips;
    logic [CNT_W-1:0] finalCnt;
  } expItem_t;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             start = 1'b0;
  logic             dirRev = 1'b0;
  logic [CNT_W-1:0] frameCountIn = '0;
  logic [GAP_W-1:0] gapCycles = '0;
  logic             skipAck = 1'b0;
  logic [1:0]       skipResp = 2'd0;
  logic             skipReq, skipDir, busy, motion, donePulse, attnReq;
  logic             errNef, errFce, tapeMark;
  logic [CNT_W-1:0] frameCount;

  int       tests = 0;
  int       fails = 0;
  int       cycle = 0;
  int       stubLat = 1;
  int       skipCount = 0;
  int       prevReqCycle = -1;
  int       expInterval = 0;
  logic     expDir = 1'b0;
  logic [1:0] respQ[$];
  expItem_t   expQ[$];
  expItem_t   lastExp;

  tape_space_seq #(.CNT_W(CNT_W), .GAP_W(GAP_W)) u_dut (
    .clk(clk), .rstN(rstN), .start(start), .dirRev(dirRev),
    .frameCountIn(frameCountIn), .gapCycles(gapCycles),
    .skipAck(skipAck), .skipResp(skipResp), .skipReq(skipReq),
    .skipDir(skipDir), .busy(busy), .motion(motion),
    .frameCount(frameCount), .donePulse(donePulse), .attnReq(attnReq),
    .errNef(errNef), .errFce(errFce), .tapeMark(tapeMark)
  );

  always #4 clk = ~clk;
  always @(posedge clk) cycle <= cycle + 1;

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // skip agent stub: one response per request after stubLat falling edges
  initial begin
    forever begin
      @(negedge clk);
      skipAck = 1'b0;
      if (skipReq) begin
        repeat (stubLat) @(negedge clk);
        skipResp = (respQ.size() > 0) ? respQ.pop_front() : 2'd0;
        skipAck  = 1'b1;
      end
    end
  end

  // request monitor: direction, motion, spacing
  initial begin
    forever begin
      @(negedge clk);
      if (skipReq) begin
        skipCount++;
        chk("R4", "skipDir", skipDir, expDir);
        chk("R10", "motion with request", motion, 1);
        if (prevReqCycle >= 0)
          chk("R6", "request spacing", cycle - prevReqCycle, expInterval);
        prevReqCycle = cycle;
      end
    end
  end

  // completion monitor: scoreboard compare
  initial begin
    forever begin
      @(negedge clk);
      if (donePulse) begin
        if (expQ.size() == 0) begin
          chk("R9", "unexpected done", 1, 0);
        end else begin
          expItem_t e;
          e = expQ.pop_front();
          lastExp = e;
          chk("R8", "errNef", errNef, e.nef);
          chk("R7", "errFce", errFce, e.fce);
          chk("R8", "tapeMark", tapeMark, e.mark);
          chk("R5", "frameCount at done", frameCount, e.finalCnt);
          chk("R4", "skip count", skipCount, e.skips);
          chk("R9", "attnReq", attnReq, 1);
          chk("R10", "motion low at done", motion, 0);
        end
        skipCount = 0;
        prevReqCycle = -1;
      end
    end
  end

  task automatic runCmd(input logic [CNT_W-1:0] cnt, input logic dir,
                        input int gap, input int lat, input bit poke);
    expItem_t e;
    logic [CNT_W-1:0] c;
    int idx;
    bit fin;
    logic [1:0] r;
    c = cnt; idx = 0; fin = 0;
    e.nef = 0; e.fce = 0; e.mark = 0; e.skips = 0;
    if (c == '0) begin
      e.nef = 1;
    end else begin
      while (!fin) begin
        e.skips++;
        r = (idx < respQ.size()) ? respQ[idx] : 2'd0;
        idx++;
        if (r == 2'd0) begin
          c = c + 1'b1;
          if (c == '0) fin = 1;
        end else begin
          e.mark = (r == 2'd1);
          e.nef  = (r == 2'd2);
          e.fce  = (c != '0);
          fin = 1;
        end
      end
    end
    e.finalCnt = c;
    expQ.push_back(e);
    stubLat = lat;
    expDir = dir;
    expInterval = lat + gap + 2;
    @(negedge clk);
    gapCycles = GAP_W'(gap);
    frameCountIn = cnt;
    dirRev = dir;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      // R2: a start while busy must be ignored
      repeat (3) @(negedge clk);
      frameCountIn = '0;
      dirRev = ~dir;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (expQ.size() != 0) @(negedge clk);
    @(negedge clk);
    chk("R9", "busy after done", busy, 0);
    chk("R9", "errNef held", errNef, lastExp.nef);
    chk("R9", "errFce held", errFce, lastExp.fce);
    chk("R9", "tapeMark held", tapeMark, lastExp.mark);
    respQ.delete();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1", "busy", busy, 0);
    chk("R1", "skipReq", skipReq, 0);
    chk("R1", "motion", motion, 0);
    chk("R1", "donePulse", donePulse, 0);
    chk("R1", "flags", {errNef, errFce, tapeMark, attnReq}, 0);
    chk("R1", "frameCount", frameCount, 0);

    runCmd(16'h0000, 1'b0, 2, 1, 0);          // R3 zero count
    runCmd(16'hFFFF, 1'b0, 0, 1, 0);          // R5 single record wrap
    runCmd(16'hFFFB, 1'b1, 3, 1, 0);          // R5/R6 five records backward
    respQ = '{2'd0, 2'd0, 2'd1};
    runCmd(16'hFFFC, 1'b0, 1, 2, 0);          // R7/R8 tape mark early
    respQ = '{2'd2};
    runCmd(16'hFFFD, 1'b1, 0, 1, 0);          // R8 beginning of tape
    respQ = '{2'd0, 2'd0, 2'd0, 2'd3};
    runCmd(16'hFFF6, 1'b0, 4, 3, 0);          // R7 end of medium
    runCmd(16'hFFFE, 1'b0, 5, 1, 1);          // R2 start while busy ignored
    runCmd(16'hFFEC, 1'b1, 2, 2, 0);          // R5 twenty records

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule